// File: doc/BRIEF.md
# Three-Stage Serial Character Buffer Chain

This block is a pipeline of three character registers that sit between a character source and a line transmitter in a display terminal. Each stage has a full flag. A character moves from one stage to the next only when the upstream stage is full and the downstream stage is empty. The move is a bit-serial burst: one start cycle, then one shift pulse per character bit. Stage 1 is loaded through a ready/valid port. Stage 3 is offered to the consumer through a valid/take handshake.

In receive mode, the load port carries characters from the line deserializer. Nothing passes stage 1 until the chain has seen a start-of-text code followed by this terminal's own address character. Characters seen before that point are consumed and dropped.

In transmit mode, the load port carries characters fetched from display memory. An initialize strobe clears stage 2 by loading the null code into it. A header strobe loads start-of-text into stage 3 and the address character into stage 2, so that the header leaves the chain ahead of the data. Once an end-of-text code is loaded, no further loads are accepted. The transmission ends when the consumer takes that end-of-text code from stage 3.

Top module: `char_chain`

## Requirements
- R1: After reset, `out_valid_o` and `tx_active_o` are 0 and `ld_ready_o` is 1.
- R2: A character loaded into an otherwise empty chain with an open gate appears bit-exact on `out_char_o`. `out_valid_o` rises exactly 16 clock edges after the load edge, because each of the two hops takes one start cycle plus seven shift pulses.
- R3: A hop starts only when its upstream stage is full and its downstream stage is empty. With the output not taken, three loads fill all stages and `out_char_o` holds the oldest character.
- R4: `ld_ready_o` is 1 only while stage 1 is empty and no end-of-text is pending. A load offered while `ld_ready_o` is 0 is dropped and never reaches the output.
- R5: In receive mode (`mode_tx_i`=0), characters are consumed and dropped until start-of-text (7'h02) is followed directly by the address character {1'b1, `dev_addr_i`}. A different character after start-of-text restarts the search.
- R6: Once the header is qualified, received characters leave stage 3 in arrival order.
- R7: `tx_init_i` in transmit mode loads the null code (7'h00) into stage 2 and marks it empty, which drops any character held there. Stage 3 is not affected.
- R8: `out_valid_o` equals the stage 3 full flag. While valid and not taken, `out_char_o` is held. A pulse on `out_take_i` empties stage 3.
- R9: In transmit mode, a character in stage 1 does not move on until `enter_hdr_i` has started a transmission.
- R10: `enter_hdr_i` in transmit mode sets `tx_active_o`. It makes the chain emit start-of-text (7'h02), then the address character {1'b1, `dev_addr_i`}, then the stage 1 characters.
- R11: In transmit mode, loading end-of-text (7'h03) drops `ld_ready_o` until that code is taken from stage 3. Taking it clears `tx_active_o` and restores `ld_ready_o`.
- R12: Entering transmit mode discards receive header qualification, so that the next receive session must see a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock; one shift pulse per cycle during a hop |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_tx_i | input | 1 | 1 = transmit mode, 0 = receive mode |
| dev_addr_i | input | 6 | Terminal address, one of 64 |
| ld_valid_i | input | 1 | Load offer into stage 1 |
| ld_char_i | input | 7 | Character to load |
| ld_ready_o | output | 1 | Stage 1 can take a load |
| tx_init_i | input | 1 | Load null into stage 2 and mark it empty |
| enter_hdr_i | input | 1 | Load start-of-text into stage 3 and the address into stage 2 |
| out_valid_o | output | 1 | Stage 3 holds a character |
| out_char_o | output | 7 | Stage 3 character |
| out_take_i | input | 1 | Consumer takes stage 3 |
| tx_active_o | output | 1 | Transmission in progress |

## Verification
The bench times a single character through both hops to the exact edge. A burst that is one pulse short or long would either corrupt the character or move the output edge away from 16. It fills the whole chain against a stalled consumer. A gate that ignored the downstream flag would overwrite the oldest character, and a load port that ignored the full flag would let a late character through. It feeds stray characters and a start-of-text with the wrong address before the real header, which catches a qualifier that opens too early or fails to restart its search. It also checks that the end-of-text code blocks loads and ends the transmission only when it is taken, and that a stale stage 2 character disappears after initialization.

// File: rtl/char_chain_pkg.sv
package char_chain_pkg;
  typedef enum logic [1:0] {HS_IDLE, HS_STX, HS_OPEN} hdr_state_e;
endpackage

// File: rtl/chain_stage.sv
module chain_stage #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         jam_i,
  input  logic [W-1:0] jam_d_i,
  input  logic         jam_full_i,
  input  logic         shift_i,
  input  logic         ser_i,
  input  logic         set_full_i,
  input  logic         clr_full_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         ser_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      full_o <= 1'b0;
    end else if (jam_i) begin
      data_o <= jam_d_i;
      full_o <= jam_full_i;
    end else begin
      if (shift_i) data_o <= {data_o[W-2:0], ser_i};
      if (set_full_i)      full_o <= 1'b1;
      else if (clr_full_i) full_o <= 1'b0;
    end
  end

  assign ser_o = data_o[W-1];
endmodule

// File: rtl/chain_mover.sv
module chain_mover #(
  parameter int W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_full_i,
  input  logic dn_full_i,
  input  logic allow_i,
  output logic active_o,
  output logic done_o
);
  localparam int CW = $clog2(W);
  logic [CW-1:0] cnt_q;
  logic          start;

  assign start  = up_full_i && !dn_full_i && allow_i;
  assign done_o = active_o && (cnt_q == CW'(W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (!active_o) begin
      if (start) active_o <= 1'b1;
      cnt_q <= '0;
    end else if (done_o) begin
      active_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r3_start_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(active_o) |-> $past(up_full_i && !dn_full_i && allow_i));
  a_r2_burst_runs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && !done_o) |=> active_o);
  a_r2_burst_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !active_o);
endmodule

// File: rtl/rx_header_gate.sv
module rx_header_gate #(
  parameter int W = 7,
  parameter logic [W-1:0] STX = 7'h02
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         seen_i,
  input  logic [W-1:0] char_i,
  input  logic [W-1:0] addr_char_i,
  output logic         open_o
);
  import char_chain_pkg::*;
  hdr_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (seen_i) begin
      unique case (st_q)
        HS_IDLE: st_d = (char_i == STX) ? HS_STX : HS_IDLE;
        HS_STX:  st_d = (char_i == addr_char_i) ? HS_OPEN :
                        (char_i == STX) ? HS_STX : HS_IDLE;
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      st_q <= HS_IDLE;
    else if (clear_i) st_q <= HS_IDLE;
    else              st_q <= st_d;
  end

  assign open_o = (st_q == HS_OPEN);

  a_r5_open_needs_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(seen_i && char_i == addr_char_i));
endmodule

// File: rtl/char_chain.sv
module char_chain #(
  parameter int ADDR_W = 6,
  parameter int NSTG   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_tx_i,
  input  logic [ADDR_W-1:0] dev_addr_i,
  input  logic              ld_valid_i,
  input  logic [ADDR_W:0]   ld_char_i,
  output logic              ld_ready_o,
  input  logic              tx_init_i,
  input  logic              enter_hdr_i,
  output logic              out_valid_o,
  output logic [ADDR_W:0]   out_char_o,
  input  logic              out_take_i,
  output logic              tx_active_o
);
  localparam int W = ADDR_W + 1;
  localparam logic [W-1:0] C_NULL = '0;
  localparam logic [W-1:0] C_STX  = W'(2);
  localparam logic [W-1:0] C_ETX  = W'(3);

  logic [W-1:0] data [NSTG];
  logic [NSTG-1:0] full, ser, jam, jam_full, shift, set_f, clr_f;
  logic [W-1:0] jam_d [NSTG];
  logic [NSTG-2:0] m_act, m_done, allow;

  logic [W-1:0] addr_char;
  logic hdr, init, ld_fire, take_fire, tx_done, etx_pend, rx_open, discard;

  assign addr_char = {1'b1, dev_addr_i};
  assign hdr       = enter_hdr_i && mode_tx_i;
  assign init      = tx_init_i && mode_tx_i;
  assign ld_ready_o = !full[0] && !(mode_tx_i && etx_pend);
  assign ld_fire   = ld_valid_i && ld_ready_o;
  assign take_fire = out_take_i && full[NSTG-1];
  assign tx_done   = mode_tx_i && tx_active_o && take_fire && (data[NSTG-1] == C_ETX);
  assign discard   = !mode_tx_i && !rx_open && full[0] && !m_act[0];

  // per-stage controls
  always_comb begin
    for (int i = 0; i < NSTG; i++) begin
      jam[i] = 1'b0; jam_d[i] = C_NULL; jam_full[i] = 1'b0;
      shift[i] = 1'b0; set_f[i] = 1'b0; clr_f[i] = 1'b0;
      if (i > 0)      begin shift[i] = shift[i] | m_act[i-1]; set_f[i] = m_done[i-1]; end
      if (i < NSTG-1) begin shift[i] = shift[i] | m_act[i];   clr_f[i] = m_done[i];   end
    end
    jam[0] = ld_fire; jam_d[0] = ld_char_i; jam_full[0] = 1'b1;
    clr_f[0] = clr_f[0] | discard;
    jam[NSTG-2] = hdr | init;
    jam_d[NSTG-2] = hdr ? addr_char : C_NULL;
    jam_full[NSTG-2] = hdr;
    jam[NSTG-1] = hdr; jam_d[NSTG-1] = C_STX; jam_full[NSTG-1] = 1'b1;
    clr_f[NSTG-1] = take_fire;
  end

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    chain_stage #(.W(W)) i_stage (
      .clk_i, .rst_ni,
      .jam_i(jam[g]), .jam_d_i(jam_d[g]), .jam_full_i(jam_full[g]),
      .shift_i(shift[g]), .ser_i((g == 0) ? 1'b0 : ser[(g == 0) ? 0 : g-1]),
      .set_full_i(set_f[g]), .clr_full_i(clr_f[g]),
      .data_o(data[g]), .full_o(full[g]), .ser_o(ser[g])
    );
  end

  for (genvar g = 0; g < NSTG-1; g++) begin : g_mover
    if (g == 0) begin : g_first
      assign allow[g] = mode_tx_i ? tx_active_o : rx_open;
    end else begin : g_rest
      assign allow[g] = 1'b1;
    end
    chain_mover #(.W(W)) i_mover (
      .clk_i, .rst_ni,
      .up_full_i(full[g]), .dn_full_i(full[g+1]), .allow_i(allow[g]),
      .active_o(m_act[g]), .done_o(m_done[g])
    );
  end

  rx_header_gate #(.W(W), .STX(C_STX)) i_gate (
    .clk_i, .rst_ni,
    .clear_i(mode_tx_i), .seen_i(discard), .char_i(data[0]),
    .addr_char_i(addr_char), .open_o(rx_open)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_active_o <= 1'b0;
      etx_pend    <= 1'b0;
    end else begin
      if (hdr)          tx_active_o <= 1'b1;
      else if (tx_done) tx_active_o <= 1'b0;
      if (hdr || tx_done) etx_pend <= 1'b0;
      else if (ld_fire && mode_tx_i && ld_char_i == C_ETX) etx_pend <= 1'b1;
    end
  end

  assign out_valid_o = full[NSTG-1];
  assign out_char_o  = data[NSTG-1];

  a_r8_out_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_take_i && !enter_hdr_i) |=> (out_valid_o && $stable(out_char_o)));
  a_r8_take_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_take_i && !enter_hdr_i) |=> !out_valid_o);
  a_r2_hop_clears_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_done[0] |=> !full[0]);
  a_r11_etx_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_tx_i && ld_fire && ld_char_i == C_ETX && !enter_hdr_i) |=> !ld_ready_o);
  a_r3_no_double_hop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(m_act[0] && m_act[NSTG-2] && NSTG == 3));
endmodule

// File: tb/test_char_chain.sv
module test_char_chain;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_tx = 1'b0, ld_valid = 1'b0, tx_init = 1'b0, enter_hdr = 1'b0, out_take = 1'b0;
  logic [5:0] dev_addr = 6'd5;
  logic [6:0] ld_char = '0;
  logic ld_ready, out_valid, tx_active;
  logic [6:0] out_char;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  char_chain i_char_chain (
    .clk_i(clk), .rst_ni(rst_n), .mode_tx_i(mode_tx), .dev_addr_i(dev_addr),
    .ld_valid_i(ld_valid), .ld_char_i(ld_char), .ld_ready_o(ld_ready),
    .tx_init_i(tx_init), .enter_hdr_i(enter_hdr), .out_valid_o(out_valid),
    .out_char_o(out_char), .out_take_i(out_take), .tx_active_o(tx_active)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [6:0] c);
    while (!ld_ready) @(negedge clk);
    ld_valid = 1'b1; ld_char = c;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic force_push(input logic [6:0] c);
    ld_valid = 1'b1; ld_char = c;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic pull(input string req, input logic [6:0] exp);
    int n = 0;
    while (!out_valid && n < 200) begin @(negedge clk); n++; end
    chk(req, out_valid ? int'(out_char) : -1, int'(exp));
    out_take = 1'b1;
    @(negedge clk);
    out_take = 1'b0;
  endtask

  task automatic expect_none(input string req, input int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    chk(req, seen, 0);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; @(negedge clk); s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 out_valid", out_valid, 0);
    chk("R1 tx_active", tx_active, 0);
    chk("R1 ld_ready", ld_ready, 1);
  endtask

  task automatic t_rx_header();
    push(7'h41);
    expect_none("R5 pre-header char dropped", 40);
    push(7'h02); push(7'h49); push(7'h41);
    expect_none("R5 wrong address restarts", 40);
    push(7'h02); push(7'h45);
    @(negedge clk); @(negedge clk);
    push(7'h11);
    repeat (15) @(negedge clk);
    chk("R2 not yet valid at edge 15", out_valid, 0);
    @(negedge clk);
    chk("R2 valid at edge 16", out_valid, 1);
    chk("R2 char exact", out_char, 7'h11);
    pull("R8 take", 7'h11);
    chk("R8 empty after take", out_valid, 0);
  endtask

  task automatic t_rx_backlog();
    push(7'h21); push(7'h22); push(7'h23);
    repeat (40) @(negedge clk);
    chk("R3 oldest at output", out_char, 7'h21);
    chk("R4 ready low when full", ld_ready, 0);
    force_push(7'h7f);
    pull("R6 order 1", 7'h21);
    pull("R6 order 2", 7'h22);
    pull("R6 order 3", 7'h23);
    expect_none("R4 refused load dropped", 40);
  endtask

  task automatic t_tx_init();
    push(7'h31); push(7'h32);
    repeat (40) @(negedge clk);
    mode_tx = 1'b1;
    @(negedge clk);
    pulse(tx_init);
    pull("R7 stage3 untouched", 7'h31);
    expect_none("R7 stage2 dropped", 40);
  endtask

  task automatic t_tx_frame();
    dev_addr = 6'h2a;
    push(7'h41);
    expect_none("R9 held before header", 40);
    pulse(enter_hdr);
    chk("R10 tx_active set", tx_active, 1);
    pull("R10 start-of-text first", 7'h02);
    pull("R10 address second", 7'h6a);
    pull("R10 data third", 7'h41);
    push(7'h42); push(7'h03);
    repeat (40) @(negedge clk);
    chk("R11 load blocked after end-of-text", ld_ready, 0);
    pull("R11 data before end", 7'h42);
    chk("R11 still active", tx_active, 1);
    pull("R11 end-of-text", 7'h03);
    chk("R11 tx_active cleared", tx_active, 0);
    chk("R11 load re-enabled", ld_ready, 1);
  endtask

  task automatic t_rx_requalify();
    mode_tx = 1'b0;
    @(negedge clk);
    push(7'h55);
    expect_none("R12 qualification discarded", 40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rx_header();
    t_rx_backlog();
    t_tx_init();
    t_tx_frame();
    t_rx_requalify();
    done = 1'b1;
  end

  initial begin
    int n = 0;
    while (!done && n < 100000) begin @(negedge clk); n++; end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule